// File: doc/BRIEF.md
# DMA Interrupt Status and Mask Unit

This unit collects the completion and fault events of a ten-channel DMA engine into one 32-bit control word and turns them into a single level-sensitive interrupt line. Each channel raises a one-cycle pulse when it finishes, and three engine-wide events also pulse: a stall, a memory FIFO running empty, and a bus error. Each pulse latches a sticky status flag. Channel, stall and FIFO-empty flags each have an enable bit. The bus-error flag always reaches the interrupt line.

Software uses a single-cycle register port: a write strobe with a data word, and a read-data bus that always shows the current contents. In one written word, a 1 in a status position clears that flag and a 1 in an enable position inverts that enable bit. Positions written as 0 keep their value. Software can therefore acknowledge events and adjust enables in one write, with no read-modify-write.

Top module: `dma_irq_status`

## Requirements
- R1: While `rst` is high at a clock edge, every status and enable bit is cleared, so after that edge `reg_rdata` reads 0 and `irq` is low.
- R2: A pulse on `chan_done_evt[i]` sets bit i (i = 0..9). A pulse on `stall_evt` sets bit 13, a pulse on `fifo_empty_evt` sets bit 14, and a pulse on `bus_err_evt` sets bit 15. The new value shows on `reg_rdata` after the next rising edge, and the flag stays set until it is cleared.
- R3: A write with `reg_we` high clears each status bit (9:0, 13, 14, 15) whose data bit is 1. Status bits written as 0 keep their value.
- R4: A write inverts each enable bit (25:16 for channels 0..9, 29 for stall, 30 for FIFO-empty) whose data bit is 1. Enable bits written as 0 keep their value.
- R5: When an event pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R6: `irq` is high exactly while some channel, stall or FIFO-empty status bit is set and its enable bit is also set, or while the bus-error bit is set. It follows the stored bits with no extra delay.
- R7: Bits 12:10, 28:26 and 31 always read 0, and writing 1s to them changes nothing.
- R8: When an enable bit is inverted to 0 while its status bit stays set, `irq` drops, provided no other source holds it high.
- R9: The bus-error bit drives `irq` with no enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| chan_done_evt | input | 10 | Per-channel completion pulses |
| stall_evt | input | 1 | Stall event pulse |
| fifo_empty_evt | input | 1 | Memory FIFO empty event pulse |
| bus_err_evt | input | 1 | Bus error event pulse |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data: 1 clears a status bit or inverts an enable bit |
| reg_rdata | output | 32 | Current status and enable bits |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that `rst` is high from time zero until at least the first rising edge, and that event and write inputs carry defined values in every cycle after reset. They place no limit on how events and writes overlap, because a collision is legal behaviour covered by R5. The stimulus drives all inputs on falling edges and holds them at known values, including zero, in every cycle. It deliberately pulses events in the same cycles as clearing writes, and writes 1s to unused positions, so that the set-wins rule and the ignored bits are exercised inside those assumptions.

// File: rtl/dma_irq_status_pkg.sv
package dma_irq_status_pkg;

    localparam int NUM_CH        = 10;
    localparam int REG_W         = 32;

    // bit positions inside the register word
    localparam int CH_STAT_LSB   = 0;
    localparam int STALL_STAT    = 13;
    localparam int FEMPTY_STAT   = 14;
    localparam int BUSERR_STAT   = 15;
    localparam int CH_EN_LSB     = 16;
    localparam int STALL_EN      = 29;
    localparam int FEMPTY_EN     = 30;

    // derived widths of the two flag banks
    localparam int STAT_W        = NUM_CH + 3;
    localparam int EN_W          = NUM_CH + 2;

    // one status flag per event source, bank order low to high
    typedef struct packed {
        logic              bus_err;
        logic              fifo_empty;
        logic              stall;
        logic [NUM_CH-1:0] chan;
    } evt_vec_t;

    // one enable bit per maskable source
    typedef struct packed {
        logic              fifo_empty;
        logic              stall;
        logic [NUM_CH-1:0] chan;
    } en_vec_t;

    // which status flags a written word acknowledges
    function automatic evt_vec_t decode_ack(input logic [REG_W-1:0] w);
        evt_vec_t r;
        r.chan       = w[CH_STAT_LSB +: NUM_CH];
        r.stall      = w[STALL_STAT];
        r.fifo_empty = w[FEMPTY_STAT];
        r.bus_err    = w[BUSERR_STAT];
        return r;
    endfunction

    // which enable bits a written word flips
    function automatic en_vec_t decode_flip(input logic [REG_W-1:0] w);
        en_vec_t r;
        r.chan       = w[CH_EN_LSB +: NUM_CH];
        r.stall      = w[STALL_EN];
        r.fifo_empty = w[FEMPTY_EN];
        return r;
    endfunction

    // assemble the readback word; every other position stays zero
    function automatic logic [REG_W-1:0] pack_word(input evt_vec_t s, input en_vec_t e);
        logic [REG_W-1:0] w;
        w                        = '0;
        w[CH_STAT_LSB +: NUM_CH] = s.chan;
        w[STALL_STAT]            = s.stall;
        w[FEMPTY_STAT]           = s.fifo_empty;
        w[BUSERR_STAT]           = s.bus_err;
        w[CH_EN_LSB +: NUM_CH]   = e.chan;
        w[STALL_EN]              = e.stall;
        w[FEMPTY_EN]             = e.fifo_empty;
        return w;
    endfunction

    // positions that carry state; the rest are reserved
    function automatic logic [REG_W-1:0] live_bits();
        evt_vec_t s;
        en_vec_t  e;
        s = '1;
        e = '1;
        return pack_word(s, e);
    endfunction

endpackage

// File: rtl/sticky_flags.sv
module sticky_flags #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] state;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                state[i] <= 1'b0;
            end else if (set_i[i]) begin
                state[i] <= 1'b1;          // set has priority over clear
            end else if (clr_i[i]) begin
                state[i] <= 1'b0;
            end
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> state[i]);                                   // R5
        AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !set_i[i]) |=> !state[i]);                   // R3
        AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!clr_i[i] && !set_i[i]) |=> $stable(state[i]));          // R2
        AST_FLAG_RESET: assert property (@(posedge clk)
            rst |=> !state[i]);                                       // R1
    end

    assign q_o = state;

endmodule

// File: rtl/toggle_enables.sv
module toggle_enables #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] flip_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] state;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                state[i] <= 1'b0;
            end else if (flip_i[i]) begin
                state[i] <= ~state[i];
            end
        end

        AST_EN_FLIPS: assert property (@(posedge clk) disable iff (rst)
            flip_i[i] |=> (state[i] != $past(state[i])));             // R4
        AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
            !flip_i[i] |=> $stable(state[i]));                        // R4
        AST_EN_RESET: assert property (@(posedge clk)
            rst |=> !state[i]);                                       // R1
    end

    assign q_o = state;

endmodule

// File: rtl/irq_reduce.sv
module irq_reduce #(
    parameter int W = 4
) (
    input  logic [W-1:0] masked_stat_i,
    input  logic [W-1:0] enable_i,
    input  logic         unmasked_i,
    output logic         irq_o
);

    logic [W-1:0] hit;

    for (genvar i = 0; i < W; i++) begin : g_and
        assign hit[i] = masked_stat_i[i] & enable_i[i];
    end

    assign irq_o = (|hit) | unmasked_i;

endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
    import dma_irq_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] chan_done_evt,
    input  logic              stall_evt,
    input  logic              fifo_empty_evt,
    input  logic              bus_err_evt,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);

    evt_vec_t evt_set;
    evt_vec_t evt_ack;
    evt_vec_t stat_q;
    en_vec_t  en_flip;
    en_vec_t  en_q;
    logic     irq_w;

    always_comb begin
        evt_set.chan       = chan_done_evt;
        evt_set.stall      = stall_evt;
        evt_set.fifo_empty = fifo_empty_evt;
        evt_set.bus_err    = bus_err_evt;
        evt_ack            = reg_we ? decode_ack(reg_wdata)  : '0;
        en_flip            = reg_we ? decode_flip(reg_wdata) : '0;
    end

    sticky_flags #(.W(STAT_W)) u_status (
        .clk   (clk),
        .rst   (rst),
        .set_i (evt_set),
        .clr_i (evt_ack),
        .q_o   (stat_q)
    );

    toggle_enables #(.W(EN_W)) u_enable (
        .clk    (clk),
        .rst    (rst),
        .flip_i (en_flip),
        .q_o    (en_q)
    );

    irq_reduce #(.W(EN_W)) u_reduce (
        .masked_stat_i ({stat_q.fifo_empty, stat_q.stall, stat_q.chan}),
        .enable_i      (en_q),
        .unmasked_i    (stat_q.bus_err),
        .irq_o         (irq_w)
    );

    assign reg_rdata = pack_word(stat_q, en_q);
    assign irq       = irq_w;

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~live_bits()) == '0);                            // R7
    AST_BUSERR_RAISES: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[BUSERR_STAT] |-> irq);                              // R9
    AST_EVT_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        stall_evt |=> reg_rdata[STALL_STAT]);                         // R2
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[CH_STAT_LSB +: NUM_CH] == '0 && !reg_rdata[STALL_STAT]
         && !reg_rdata[FEMPTY_STAT] && !reg_rdata[BUSERR_STAT]) |-> !irq); // R6

endmodule

// File: tb/test_dma_irq_status.sv
module test_dma_irq_status;

    localparam int NCH = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] chan_done_evt = '0;
    logic           stall_evt = 1'b0;
    logic           fifo_empty_evt = 1'b0;
    logic           bus_err_evt = 1'b0;
    logic           reg_we = 1'b0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic           irq;

    always #5 clk = ~clk;

    dma_irq_status i_dma_irq_status (
        .clk            (clk),
        .rst            (rst),
        .chan_done_evt  (chan_done_evt),
        .stall_evt      (stall_evt),
        .fifo_empty_evt (fifo_empty_evt),
        .bus_err_evt    (bus_err_evt),
        .reg_we         (reg_we),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .irq            (irq)
    );

    typedef struct {
        logic [31:0] word;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 0;
    logic [31:0] m_stat   = '0;
    logic [31:0] m_en     = '0;

    localparam logic [31:0] STAT_POS = 32'h0000_E3FF;
    localparam logic [31:0] EN_POS   = 32'h63FF_0000;

    function automatic logic model_irq(input logic [31:0] s, input logic [31:0] e);
        logic r;
        r = s[15];
        for (int i = 0; i < NCH; i++) r = r | (s[i] & e[16+i]);
        r = r | (s[13] & e[29]) | (s[14] & e[30]);
        return r;
    endfunction

    // driver: apply one cycle of stimulus and queue the expected outcome
    task automatic step(input logic r, input logic [NCH-1:0] ch, input logic st,
                        input logic fe, input logic be, input logic we,
                        input logic [31:0] d, input string tag);
        logic [31:0] setv;
        exp_t        x;
        @(negedge clk);
        rst = r; chan_done_evt = ch; stall_evt = st; fifo_empty_evt = fe;
        bus_err_evt = be; reg_we = we; reg_wdata = d;
        setv = 32'(ch) | (32'(st) << 13) | (32'(fe) << 14) | (32'(be) << 15);
        if (r) begin
            m_stat = '0; m_en = '0;
        end else begin
            m_stat = (m_stat & ~(we ? (d & STAT_POS) : 32'h0)) | setv;
            m_en   = m_en ^ (we ? (d & EN_POS) : 32'h0);
        end
        x.word = m_stat | m_en;
        x.irq  = model_irq(m_stat, m_en);
        x.tag  = tag;
        sb.push_back(x);
    endtask

    // monitor: after each rising edge compare one queued item
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t x;
                x = sb.pop_front();
                n_checks++;
                if (reg_rdata !== x.word || irq !== x.irq) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                             x.tag, reg_rdata, irq, x.word, x.irq);
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(1, '0, 0, 0, 0, 0, '0, "R1 reset");
        step(1, '0, 0, 0, 0, 1, 32'hFFFF_FFFF, "R1 reset ignores write");
        step(0, '0, 0, 0, 0, 0, '0, "R1 idle after reset");
        // R2: events latch and stay
        step(0, 10'h201, 0, 0, 0, 0, '0, "R2 channel 0 and 9 set");
        step(0, '0, 1, 1, 0, 0, '0, "R2 stall and fifo set");
        step(0, '0, 0, 0, 0, 0, '0, "R2 flags sticky");
        // R4: flip enables
        step(0, '0, 0, 0, 0, 1, 32'h6201_0000, "R4 flip ch0 ch9 stall fifo enables");
        step(0, '0, 0, 0, 0, 1, 32'h0001_0000, "R4 flip ch0 enable back");
        // R8: turn off enables with status still set
        step(0, '0, 0, 0, 0, 1, 32'h6200_0000, "R8 drop remaining enables");
        // R3: clear selected status bits
        step(0, '0, 0, 0, 0, 1, 32'h0000_2001, "R3 clear ch0 and stall");
        step(0, '0, 0, 0, 0, 1, 32'h0000_4200, "R3 clear ch9 and fifo");
        // R6: irq from a single enabled channel
        step(0, 10'h010, 0, 0, 0, 1, 32'h0010_0000, "R6 ch4 set and enabled");
        step(0, '0, 0, 0, 0, 1, 32'h0000_0010, "R6 clear ch4 drops irq");
        // R5: set beats clear
        step(0, 10'h008, 0, 0, 0, 1, 32'h0000_0008, "R5 ch3 set and clear collide");
        step(0, '0, 1, 0, 0, 1, 32'h0000_2000, "R5 stall set and clear collide");
        // R9: bus error without enable
        step(0, '0, 0, 0, 1, 0, '0, "R9 bus error raises irq");
        step(0, '0, 0, 0, 1, 1, 32'h0000_8000, "R5 bus error collide");
        step(0, '0, 0, 0, 0, 1, 32'h0000_8000, "R9 bus error cleared");
        // R7: reserved bits
        step(0, '0, 0, 0, 0, 1, 32'h9C00_1C00, "R7 reserved write ignored");
        step(0, '0, 0, 0, 0, 0, '0, "R7 reserved read zero");
        // mixed traffic
        step(0, 10'h3FF, 1, 1, 0, 1, 32'h63FF_0000, "R2 all events with all enables");
        step(0, '0, 0, 0, 0, 1, 32'h0000_63FF, "R3 clear all maskable");
        step(0, '0, 0, 0, 0, 0, '0, "R6 idle final");
        step(1, '0, 0, 0, 0, 0, '0, "R1 reset again");
        step(0, '0, 0, 0, 0, 0, '0, "R1 after second reset");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule